// File: doc/BRIEF.md
# Power Mode Controller

This block holds the power-control byte of an 8-bit microcontroller core and turns it into two clock enables: one for the CPU and one for the peripheral group (timers, serial port and interrupt logic). Software writes the byte over a plain SFR bus. Writing the idle bit stops the CPU clock while peripherals keep running. Writing the power-down bit stops both clocks.

Idle is left in hardware when an enabled interrupt is pending. Power-down is left only through a qualified hardware reset. The block watches a synchronized external reset level and accepts it as a reset only after it has stayed high for two full machine cycles. It reports the current mode, the baud-doubling bit and the qualified reset it produced.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After `rst`, the control byte reads 00h, `pwr_mode` is 00 (run), `cpu_clk_en` and `per_clk_en` are 1, and `core_rst` is 0.
- R2: The control byte responds only at SFR address 87h, as a whole byte. A write to any other address changes nothing, and a read at any other address returns 00h. Bit layout: bit 7 baud doubling, bits 3 and 2 general flags, bit 1 power-down, bit 0 idle.
- R3: Bits 6 to 4 always read 0, whatever was written to them.
- R4: Bit 7 and bits 3:2 are plain storage. Bit 7 is driven on `baud_dbl`. The flags have no effect on the mode or on the enables.
- R5: A write with bit 0 set and bit 1 clear enters idle on the clock edge after the write: `pwr_mode` = 01, `cpu_clk_en` = 0, `per_clk_en` = 1. During the write cycle itself, both enables stay 1.
- R6: A write with bit 1 set enters power-down on the next edge: `pwr_mode` = 10, and both enables are 0.
- R7: When bits 1 and 0 are written as 1 together, power-down wins and bit 0 reads back 0.
- R8: In idle, a high `irq_pend` at an edge clears bit 0 at that edge and returns to run. All other bits keep their values.
- R9: `irq_pend` has no effect in run mode or in power-down.
- R10: `core_rst` rises once `ext_rst` has been high at 24 consecutive edges (2 machine cycles of 12 periods). At the next edge it clears the control byte to 00h and returns to run. A high level lasting 23 edges has no effect.
- R11: SFR writes are ignored while the mode is idle or power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock, one oscillator period |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_rst | input | 1 | Synchronized external reset level, to be qualified |
| irq_pend | input | 1 | An enabled interrupt is pending |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | Control byte when the address matches, else 00h |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| pwr_mode | output | 2 | 00 run, 01 idle, 10 power-down |
| baud_dbl | output | 1 | Baud-rate doubling bit |
| core_rst | output | 1 | Qualified hardware reset |

## Verification
The bench writes all 256 byte values to the control address, and writes to every other address. This exposes a design that lets idle survive a combined write, leaks reserved bits, or decodes a stray address. From each resulting mode, it applies an interrupt: a design that wakes from power-down or loses the flags on wake fails there. It then applies reset pulses of 23 and 24 edges; an off-by-one qualifier would either never release power-down or release it early. Writes attempted while stopped catch a design that lets the bus disturb a sleeping core.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'b00,
        MODE_IDLE  = 2'b01,
        MODE_PDOWN = 2'b10
    } pwr_mode_e;

    localparam int BIT_IDL  = 0;
    localparam int BIT_PD   = 1;
    localparam int BIT_GF0  = 2;
    localparam int BIT_GF1  = 3;
    localparam int BIT_SMOD = 7;

    typedef struct packed {
        logic       smod;
        logic [1:0] gf;
        logic       pd;
        logic       idl;
    } ctl_reg_t;

    // Power-down outranks idle when both arrive in one write.
    function automatic ctl_reg_t decode_write(input logic [7:0] d);
        ctl_reg_t r;
        r.smod = d[BIT_SMOD];
        r.gf   = {d[BIT_GF1], d[BIT_GF0]};
        r.pd   = d[BIT_PD];
        r.idl  = d[BIT_IDL] & ~d[BIT_PD];
        return r;
    endfunction

    function automatic logic [7:0] pack_reg(input ctl_reg_t r);
        return {r.smod, 3'b000, r.gf, r.pd, r.idl};
    endfunction

endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
    parameter int LEN = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_rst,
    output logic qual_rst
);
    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(LEN);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !ext_rst) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign qual_rst = (cnt == CNT_MAX);
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import pwr_mode_pkg::*;
#(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h87
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              irq_pend,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output ctl_reg_t          reg_q
);
    logic hit;
    logic running;

    assign hit     = (sfr_addr == CTL_ADDR);
    assign running = ~(reg_q.pd | reg_q.idl);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            reg_q <= '0;
        end else if (sfr_wr && hit && running) begin
            reg_q <= decode_write(sfr_wdata);
        end else if (irq_pend && reg_q.idl && !reg_q.pd) begin
            reg_q.idl <= 1'b0;
        end
    end

    assign sfr_rdata = hit ? pack_reg(reg_q) : 8'h00;
endmodule

// File: rtl/pwr_gate_dec.sv
module pwr_gate_dec
    import pwr_mode_pkg::*;
(
    input  ctl_reg_t  reg_q,
    output pwr_mode_e mode,
    output logic      cpu_en,
    output logic      per_en
);
    always_comb begin
        if (reg_q.pd)       mode = MODE_PDOWN;
        else if (reg_q.idl) mode = MODE_IDLE;
        else                mode = MODE_RUN;
    end

    always_comb begin
        case (mode)
            MODE_RUN:  begin cpu_en = 1'b1; per_en = 1'b1; end
            MODE_IDLE: begin cpu_en = 1'b0; per_en = 1'b1; end
            default:   begin cpu_en = 1'b0; per_en = 1'b0; end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
    import pwr_mode_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR   = 8'h87,
    parameter int                OSC_PER_MC = 12,
    parameter int                RST_MC     = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_rst,
    input  logic              irq_pend,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_wr,
    input  logic [7:0]        sfr_wdata,
    output logic [7:0]        sfr_rdata,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic [1:0]        pwr_mode,
    output logic              baud_dbl,
    output logic              core_rst
);
    localparam int RST_LEN = OSC_PER_MC * RST_MC;

    ctl_reg_t  reg_q;
    pwr_mode_e mode;

    pwr_rst_qual #(.LEN(RST_LEN)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .ext_rst  (ext_rst),
        .qual_rst (core_rst)
    );

    pwr_ctl_reg #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .clr       (core_rst),
        .irq_pend  (irq_pend),
        .sfr_addr  (sfr_addr),
        .sfr_wr    (sfr_wr),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .reg_q     (reg_q)
    );

    pwr_gate_dec u_dec (
        .reg_q  (reg_q),
        .mode   (mode),
        .cpu_en (cpu_clk_en),
        .per_en (per_clk_en)
    );

    assign pwr_mode = mode;
    assign baud_dbl = reg_q.smod;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h87
) (
    input logic              clk,
    input logic              rst,
    input logic              ext_rst,
    input logic              irq_pend,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_wr,
    input logic [7:0]        sfr_wdata,
    input logic              cpu_clk_en,
    input logic              per_clk_en,
    input logic [1:0]        pwr_mode,
    input logic              core_rst
);
    p_idle_gate_r5: assert property (@(posedge clk) disable iff (rst)
        pwr_mode == 2'b01 |-> (!cpu_clk_en && per_clk_en));

    p_pdown_gate_r6: assert property (@(posedge clk) disable iff (rst)
        pwr_mode == 2'b10 |-> (!cpu_clk_en && !per_clk_en));

    p_pd_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (sfr_wr && sfr_addr == CTL_ADDR && sfr_wdata[1] && pwr_mode == 2'b00 && !core_rst)
        |=> pwr_mode == 2'b10);

    p_idle_wake_r8: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'b01 && irq_pend && !core_rst) |=> pwr_mode == 2'b00);

    p_pd_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'b10 && !core_rst) |=> pwr_mode == 2'b10);

    p_qual_src_r10: assert property (@(posedge clk) disable iff (rst)
        core_rst |-> $past(ext_rst));

    p_qual_clears_r10: assert property (@(posedge clk) disable iff (rst)
        core_rst |=> pwr_mode == 2'b00);

    p_idle_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_mode == 2'b01 && !irq_pend && !core_rst) |=> pwr_mode == 2'b01);
endmodule

bind pwr_mode_ctl pwr_mode_chk #(.ADDR_W(ADDR_W), .CTL_ADDR(CTL_ADDR)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_rst    (ext_rst),
    .irq_pend   (irq_pend),
    .sfr_addr   (sfr_addr),
    .sfr_wr     (sfr_wr),
    .sfr_wdata  (sfr_wdata),
    .cpu_clk_en (cpu_clk_en),
    .per_clk_en (per_clk_en),
    .pwr_mode   (pwr_mode),
    .core_rst   (core_rst)
);

// File: tb/tb_pwr_mode_ctl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctl;
    localparam logic [7:0] CTL = 8'h87;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_rst = 1'b0;
    logic       irq_pend = 1'b0;
    logic [7:0] sfr_addr = CTL;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       cpu_clk_en, per_clk_en, baud_dbl, core_rst;
    logic [1:0] pwr_mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    pwr_mode_ctl dut (
        .clk(clk), .rst(rst), .ext_rst(ext_rst), .irq_pend(irq_pend),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .pwr_mode(pwr_mode), .baud_dbl(baud_dbl), .core_rst(core_rst)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        sfr_addr = a; sfr_wdata = d; sfr_wr = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; sfr_addr = CTL;
    endtask

    task automatic hold_ext(input int n);
        ext_rst = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk("R1 rdata", sfr_rdata, 8'h00);
        chk("R1 mode", pwr_mode, 0);
        chk("R1 cpu_en", cpu_clk_en, 1);
        chk("R1 per_en", per_clk_en, 1);
        chk("R1 core_rst", core_rst, 0);

        // R2: other addresses neither write nor read back
        for (int a = 0; a < 256; a++) begin
            if (a[7:0] != CTL) begin
                wr_byte(a[7:0], 8'h8F);
                sfr_addr = a[7:0]; #1;
                chk("R2 foreign read", sfr_rdata, 8'h00);
                sfr_addr = CTL; #1;
                chk("R2 foreign write", sfr_rdata, 8'h00);
                chk("R2 mode", pwr_mode, 0);
            end
        end

        for (int v = 0; v < 256; v++) begin
            logic [7:0] d;
            logic [7:0] exp;
            int         em;
            d   = v[7:0];
            exp = d & 8'h8F;            // R3: bits 6:4 read 0
            if (d[1]) exp[0] = 1'b0;    // R7: power-down wins
            em  = d[1] ? 2 : (d[0] ? 1 : 0);

            sfr_addr = CTL; sfr_wdata = d; sfr_wr = 1'b1; #1;
            chk("R5 enable during write", cpu_clk_en, 1);
            @(negedge clk);
            sfr_wr = 1'b0;
            chk("R3 R7 readback", sfr_rdata, exp);
            chk("R5 R6 R7 mode", pwr_mode, em);
            chk("R4 baud_dbl", baud_dbl, d[7]);
            chk("R5 R6 cpu_en", cpu_clk_en, (em == 0) ? 1 : 0);
            chk("R4 R5 R6 per_en", per_clk_en, (em == 2) ? 0 : 1);

            if (em != 0) begin
                wr_byte(CTL, 8'h00);
                chk("R11 write ignored", sfr_rdata, exp);
                chk("R11 mode kept", pwr_mode, em);
            end

            irq_pend = 1'b1;
            @(negedge clk);
            irq_pend = 1'b0;
            if (em == 1) begin
                chk("R8 wake mode", pwr_mode, 0);
                chk("R8 bits kept", sfr_rdata, exp & 8'hFE);
                chk("R8 cpu_en", cpu_clk_en, 1);
            end else begin
                chk("R9 irq ignored", sfr_rdata, exp);
                chk("R9 mode", pwr_mode, em);
            end

            if (em == 2) begin
                hold_ext(23);
                chk("R10 short core_rst", core_rst, 0);
                ext_rst = 1'b0;
                @(negedge clk);
                chk("R10 short no effect", pwr_mode, 2);
                chk("R10 short byte kept", sfr_rdata, exp);
                hold_ext(24);
                chk("R10 core_rst rises", core_rst, 1);
                ext_rst = 1'b0;
                @(negedge clk);
                chk("R10 core_rst falls", core_rst, 0);
                chk("R10 cleared", sfr_rdata, 8'h00);
                chk("R10 mode run", pwr_mode, 0);
            end
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule